// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a two-port memory in which one port can only write and the other can only read. Both ports can act on the same clock edge, and each port has its own clock. The two ports view the same storage bits, but each can use its own word width. The widths come from one of two families. The power-of-two family offers 1, 2, 4, 8, 16 and 32 bits over 8192 storage bits. The nine-multiple family offers 9, 18 and 36 bits over 9216 storage bits. The two ports must use widths from the same family, and elaboration stops with an error for any other pairing.

The write port has byte enables, a clock enable and an address-stall input. The read port has a read enable, a clock enable, an address-stall input and an output register that a parameter can add. A synchronous active-high reset clears the read data path and leaves the stored contents unchanged. Typical uses are width converters and packet buffers, where a narrow producer writes and a wide consumer reads, or the reverse.

Top module: `mw_sdp_ram`

## Requirements
- R1: Addresses map little-endian. The word at address n of a port with width W occupies storage bits [n*W +: W]. A wide word therefore holds consecutive narrow words, with the lowest address in the least significant bits. This holds whether the write port or the read port is the wider one.
- R2: With OUT_REG=0, rd_q shows the addressed data after the first read-clock edge that accepts the read. With OUT_REG=1, rd_q changes one read-clock edge later, provided rd_ce is high on that edge.
- R3: Bit b of wr_be enables write-data bits [b*8 +: 8] (9-bit bytes in the nine-multiple family). Bytes whose enable is low keep their previous contents. A write port narrower than one byte has a single enable covering the whole word.
- R4: A read that targets the location written on the same edge returns the contents from before the write.
- R5: A write and a read to different locations on the same edge both take effect.
- R6: While a port's stall input is high, that port uses its previously latched address instead of the address input, and the latched address does not change.
- R7: While a port's clock enable is low, that port does nothing. No write takes place, no address is latched, and the read data and output register do not change.
- R8: A high rst on a read-clock edge sets the read data and the output register to zero. The stored contents are not affected.
- R9: While rd_en is low, rd_q keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_ce | input | 1 | Write port clock enable |
| wr_en | input | 1 | Write request |
| wr_stall | input | 1 | Reuse the previously latched write address |
| wr_addr | input | WA_W | Write word address |
| wr_data | input | WR_W | Write data |
| wr_be | input | NBE | Byte enables |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset of the read data path (read clock) |
| rd_ce | input | 1 | Read port clock enable |
| rd_en | input | 1 | Read request |
| rd_stall | input | 1 | Reuse the previously latched read address |
| rd_addr | input | RA_W | Read word address |
| rd_q | output | RD_W | Read data |

## Verification
The hardest case to reach from the ports is one where the latched read address differs from the address input. When that happens, a stall or a disabled clock enable can only be told apart from normal operation through the data it returns. The stimulus first reads one word. It then presents a different address while rd_ce is low, and then stalls a read with that new address still on the input. The two candidate words hold different contents, so any latch taken during the disabled cycle appears at rd_q. A second case is a same-edge write and read to one location, which is driven from a single shared clock so that the old-data result is well defined.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {FAM_NONE, FAM_POW2, FAM_NINE} width_family_e;

  function automatic width_family_e family_of(input int w);
    if (w == 1 || w == 2 || w == 4 || w == 8 || w == 16 || w == 32)
      return FAM_POW2;
    if (w == 9 || w == 18 || w == 36)
      return FAM_NINE;
    return FAM_NONE;
  endfunction

  function automatic bit widths_ok(input int wa, input int wb);
    return (family_of(wa) != FAM_NONE) && (family_of(wa) == family_of(wb));
  endfunction

endpackage

// File: rtl/mw_addr_latch.sv
module mw_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          stall,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff,
  output logic [AW-1:0] addr_q
);

  always_comb addr_eff = stall ? addr_q : addr_in;

  always_ff @(posedge clk) begin
    if (ce) addr_q <= addr_eff;
  end

  // R6
  stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && stall) |=> $stable(addr_q));

  // R6
  take_new_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !stall) |=> (addr_q == $past(addr_in)));

  // R7
  ce_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(addr_q));

endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int WR_W   = 8,
  parameter int RD_W   = 32,
  parameter int TOTAL  = 8192,
  parameter int BYTE_W = 8,
  parameter int NBE    = 1,
  parameter int BSZ    = 8,
  parameter int WA_W   = 10,
  parameter int RA_W   = 8
) (
  input  logic            wr_clk,
  input  logic            we,
  input  logic [WA_W-1:0] waddr,
  input  logic [WR_W-1:0] wdata,
  input  logic [NBE-1:0]  wbe,
  input  logic            rd_clk,
  input  logic            rst,
  input  logic            re,
  input  logic [RA_W-1:0] raddr,
  output logic [RD_W-1:0] rdata
);

  localparam int MAX_W  = (WR_W > RD_W) ? WR_W : RD_W;
  localparam int MWORDS = TOTAL / MAX_W;
  localparam int WRATIO = MAX_W / WR_W;
  localparam int RRATIO = MAX_W / RD_W;
  localparam int MI_W   = $clog2(MWORDS);
  localparam int BASE_W = $clog2(MAX_W) + 1;

  logic [MAX_W-1:0]  mem [MWORDS];
  logic [MI_W-1:0]   w_word, r_word;
  logic [BASE_W-1:0] w_base, r_base;

  initial begin
    for (int i = 0; i < MWORDS; i++) mem[i] = '0;
  end

  always_comb begin
    w_word = MI_W'(int'(waddr) / WRATIO);
    w_base = BASE_W'((int'(waddr) % WRATIO) * WR_W);
    r_word = MI_W'(int'(raddr) / RRATIO);
    r_base = BASE_W'((int'(raddr) % RRATIO) * RD_W);
  end

  always_ff @(posedge wr_clk) begin
    if (we) begin
      for (int b = 0; b < NBE; b++) begin
        if (wbe[b])
          mem[w_word][BASE_W'(int'(w_base) + b * BYTE_W) +: BSZ] <= wdata[b * BYTE_W +: BSZ];
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[r_word][r_base +: RD_W];
  end

  // R9
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !re |=> $stable(rdata));

  // R8
  rd_clear_chk: assert property (@(posedge rd_clk)
    rst |=> (rdata == '0));

endmodule

// File: rtl/mw_rd_out.sv
module mw_rd_out #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= rdata;
      end
      assign q = q_r;

      // R2
      out_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !rst) |=> (q == $past(rdata)));
    end else begin : g_flow
      assign q = rdata;

      // R7
      out_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));
    end
  endgenerate

  // R8
  out_clear_chk: assert property (@(posedge clk)
    rst |=> (q == '0));

endmodule

// File: rtl/mw_sdp_ram.sv
module mw_sdp_ram
  import mw_pkg::*;
#(
  parameter int WR_W      = 8,
  parameter int RD_W      = 32,
  parameter bit OUT_REG   = 1'b0,
  parameter int POW2_BITS = 8192,
  parameter int NINE_BITS = 9216,
  localparam bit IS_NINE  = (family_of(WR_W) == FAM_NINE),
  localparam int TOTAL    = IS_NINE ? NINE_BITS : POW2_BITS,
  localparam int BYTE_W   = IS_NINE ? 9 : 8,
  localparam int NBE      = (WR_W >= BYTE_W) ? WR_W / BYTE_W : 1,
  localparam int BSZ      = (WR_W >= BYTE_W) ? BYTE_W : WR_W,
  localparam int WA_W     = $clog2(TOTAL / WR_W),
  localparam int RA_W     = $clog2(TOTAL / RD_W)
) (
  input  logic            wr_clk,
  input  logic            wr_ce,
  input  logic            wr_en,
  input  logic            wr_stall,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [WR_W-1:0] wr_data,
  input  logic [NBE-1:0]  wr_be,
  input  logic            rd_clk,
  input  logic            rst,
  input  logic            rd_ce,
  input  logic            rd_en,
  input  logic            rd_stall,
  input  logic [RA_W-1:0] rd_addr,
  output logic [RD_W-1:0] rd_q
);

  generate
    if (!widths_ok(WR_W, RD_W)) begin : g_bad_cfg
      $error("mw_sdp_ram: port widths %0d and %0d are not a legal pairing", WR_W, RD_W);
    end
  endgenerate

  logic [WA_W-1:0] w_eff, w_hold;
  logic [RA_W-1:0] r_eff, r_hold;
  logic [RD_W-1:0] r_data;
  logic            w_go, r_go;

  assign w_go = wr_ce & wr_en;
  assign r_go = rd_ce & rd_en;

  mw_addr_latch #(.AW(WA_W)) u_wlatch (
    .clk(wr_clk), .rst(rst), .ce(wr_ce), .stall(wr_stall),
    .addr_in(wr_addr), .addr_eff(w_eff), .addr_q(w_hold)
  );

  mw_addr_latch #(.AW(RA_W)) u_rlatch (
    .clk(rd_clk), .rst(rst), .ce(rd_ce), .stall(rd_stall),
    .addr_in(rd_addr), .addr_eff(r_eff), .addr_q(r_hold)
  );

  mw_store #(
    .WR_W(WR_W), .RD_W(RD_W), .TOTAL(TOTAL), .BYTE_W(BYTE_W),
    .NBE(NBE), .BSZ(BSZ), .WA_W(WA_W), .RA_W(RA_W)
  ) u_store (
    .wr_clk(wr_clk), .we(w_go), .waddr(w_eff), .wdata(wr_data), .wbe(wr_be),
    .rd_clk(rd_clk), .rst(rst), .re(r_go), .raddr(r_eff), .rdata(r_data)
  );

  mw_rd_out #(.W(RD_W), .OUT_REG(OUT_REG)) u_out (
    .clk(rd_clk), .rst(rst), .ce(rd_ce), .rdata(r_data), .q(rd_q)
  );

  // R6
  stall_path_chk: assert property (@(posedge rd_clk) disable iff (rst)
    rd_stall |-> (r_eff == r_hold));

  // R6
  wstall_path_chk: assert property (@(posedge wr_clk) disable iff (rst)
    wr_stall |-> (w_eff == w_hold));

endmodule

// File: tb/sim_mw_sdp_ram.sv
module sim_mw_sdp_ram;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  // u0: write 8 bits, read 32 bits, no output register
  logic       w0_ce, w0_en, w0_st, r0_ce, r0_en, r0_st;
  logic [9:0] w0_addr;
  logic [7:0] w0_data;
  logic [0:0] w0_be;
  logic [7:0] r0_addr;
  logic [31:0] q0;

  // u1: write 32 bits, read 8 bits, output register
  logic       w1_ce, w1_en, r1_ce, r1_en;
  logic [7:0] w1_addr;
  logic [31:0] w1_data;
  logic [3:0] w1_be;
  logic [9:0] r1_addr;
  logic [7:0] q1;

  mw_sdp_ram #(.WR_W(8), .RD_W(32), .OUT_REG(1'b0)) u0 (
    .wr_clk(clk), .wr_ce(w0_ce), .wr_en(w0_en), .wr_stall(w0_st),
    .wr_addr(w0_addr), .wr_data(w0_data), .wr_be(w0_be),
    .rd_clk(clk), .rst(rst), .rd_ce(r0_ce), .rd_en(r0_en), .rd_stall(r0_st),
    .rd_addr(r0_addr), .rd_q(q0)
  );

  mw_sdp_ram #(.WR_W(32), .RD_W(8), .OUT_REG(1'b1)) u1 (
    .wr_clk(clk), .wr_ce(w1_ce), .wr_en(w1_en), .wr_stall(1'b0),
    .wr_addr(w1_addr), .wr_data(w1_data), .wr_be(w1_be),
    .rd_clk(clk), .rst(rst), .rd_ce(r1_ce), .rd_en(r1_en), .rd_stall(1'b0),
    .rd_addr(r1_addr), .rd_q(q1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr0(input logic [9:0] a, input logic [7:0] d);
    w0_ce = 1'b1; w0_en = 1'b1; w0_addr = a; w0_data = d; w0_be = 1'b1;
    @(negedge clk);
    w0_en = 1'b0;
  endtask

  task automatic rd0(input logic [7:0] a);
    r0_ce = 1'b1; r0_en = 1'b1; r0_addr = a;
    @(negedge clk);
    r0_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 reset q u0", q0, 32'h0);
    check("R8 reset q u1", {24'h0, q1}, 32'h0);
  endtask

  task automatic t_mapping;
    wr0(10'd4, 8'h11); wr0(10'd5, 8'h22); wr0(10'd6, 8'h33); wr0(10'd7, 8'h44);
    rd0(8'd1);
    check("R1 narrow-to-wide mapping", q0, 32'h44332211);
    check("R2 unregistered latency", q0, 32'h44332211);
  endtask

  task automatic t_collide;
    w0_ce = 1'b1; w0_en = 1'b1; w0_addr = 10'd4; w0_data = 8'h99; w0_be = 1'b1;
    r0_ce = 1'b1; r0_en = 1'b1; r0_addr = 8'd1;
    @(negedge clk);
    w0_en = 1'b0; r0_en = 1'b0;
    check("R4 old data on same-location read", q0, 32'h44332211);
    rd0(8'd1);
    check("R4 write landed after collision", q0, 32'h44332299);
  endtask

  task automatic t_parallel;
    w0_ce = 1'b1; w0_en = 1'b1; w0_addr = 10'd8; w0_data = 8'h55; w0_be = 1'b1;
    r0_ce = 1'b1; r0_en = 1'b1; r0_addr = 8'd1;
    @(negedge clk);
    w0_en = 1'b0; r0_en = 1'b0;
    check("R5 read alongside write", q0, 32'h44332299);
    rd0(8'd2);
    check("R5 write alongside read", q0, 32'h00000055);
  endtask

  task automatic t_stall;
    rd0(8'd1);
    r0_st = 1'b1; r0_en = 1'b1; r0_addr = 8'd2;
    @(negedge clk);
    r0_st = 1'b0; r0_en = 1'b0;
    check("R6 read stall keeps address", q0, 32'h44332299);
    wr0(10'd12, 8'h66);
    w0_st = 1'b1;
    wr0(10'd13, 8'h77);
    w0_st = 1'b0;
    rd0(8'd3);
    check("R6 write stall keeps address", q0, 32'h00000077);
  endtask

  task automatic t_ce;
    w0_ce = 1'b0; w0_en = 1'b1; w0_addr = 10'd13; w0_data = 8'hEE;
    @(negedge clk);
    w0_ce = 1'b1; w0_en = 1'b0;
    rd0(8'd3);
    check("R7 write ignored with ce low", q0, 32'h00000077);
    rd0(8'd1);
    r0_ce = 1'b0; r0_en = 1'b1; r0_addr = 8'd3;
    @(negedge clk);
    check("R7 read ignored with ce low", q0, 32'h44332299);
    r0_ce = 1'b1; r0_st = 1'b1;
    @(negedge clk);
    r0_st = 1'b0; r0_en = 1'b0;
    check("R7 no address latched with ce low", q0, 32'h44332299);
  endtask

  task automatic t_hold;
    r0_ce = 1'b1; r0_en = 1'b0; r0_addr = 8'd3;
    @(negedge clk);
    @(negedge clk);
    check("R9 q holds with read enable low", q0, 32'h44332299);
  endtask

  task automatic t_clear;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset clears read data", q0, 32'h0);
    rd0(8'd1);
    check("R8 reset keeps memory", q0, 32'h44332299);
  endtask

  task automatic rd1(input logic [9:0] a, output logic [7:0] early, output logic [7:0] late);
    r1_en = 1'b1; r1_addr = a;
    @(negedge clk);
    r1_en = 1'b0;
    early = q1;
    @(negedge clk);
    late = q1;
  endtask

  task automatic t_bytes;
    logic [7:0] e, l;
    w1_ce = 1'b1; w1_en = 1'b1; w1_addr = 8'd0; w1_data = 32'hAABBCCDD; w1_be = 4'hF;
    @(negedge clk);
    w1_data = 32'h11223344; w1_be = 4'b0101;
    @(negedge clk);
    w1_en = 1'b0;
    rd1(10'd3, e, l);
    check("R2 registered output not yet updated", {24'h0, e}, 32'h0);
    check("R3 disabled top byte kept", {24'h0, l}, 32'h000000AA);
    rd1(10'd0, e, l);
    check("R2 registered output one edge later", {24'h0, e}, 32'h000000AA);
    check("R3 enabled byte 0 written", {24'h0, l}, 32'h00000044);
    rd1(10'd1, e, l);
    check("R3 disabled byte 1 kept", {24'h0, l}, 32'h000000CC);
    rd1(10'd2, e, l);
    check("R1 wide-to-narrow mapping byte 2", {24'h0, l}, 32'h00000022);
  endtask

  initial begin
    rst = 1'b1;
    w0_ce = 1'b1; w0_en = 1'b0; w0_st = 1'b0; w0_addr = '0; w0_data = '0; w0_be = 1'b1;
    r0_ce = 1'b1; r0_en = 1'b0; r0_st = 1'b0; r0_addr = '0;
    w1_ce = 1'b1; w1_en = 1'b0; w1_addr = '0; w1_data = '0; w1_be = '0;
    r1_ce = 1'b1; r1_en = 1'b0; r1_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_mapping;
    t_collide;
    t_parallel;
    t_stall;
    t_ce;
    t_hold;
    t_clear;
    t_bytes;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule